// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Unit

This block is the purely combinational arithmetic and logic stage of a small accumulator processor. Each cycle the surrounding datapath presents an operation code, the accumulator, a second byte operand and the current flag byte. The block answers in the same cycle with a result byte, a new flag byte and a write-enable that tells the datapath whether the result should be stored.

Binary arithmetic, comparison, bitwise logic, increment and decrement, accumulator inversion, carry manipulation and packed-BCD correction are all handled here. Each operation has its own flag rules. Increment and decrement work on the second operand, so the datapath can route any register through them. Compare reports flags only. Undefined codes change nothing.

Operand fetch, the register file, memory and instruction timing belong to the surrounding CPU. The block has no clock, so it has no stream handshake. The inputs are sampled by whatever register stage consumes the outputs.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 invert accumulator, 11 set carry, 12 invert carry and 13 decimal adjust. The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 of `flags_o` always read zero.
- R2: Add (code 0) and add-with-carry (code 1, which also adds incoming C) return the low 8 bits of the sum. They set Z when that byte is zero, clear N, set H on a carry out of bit 3, and set C on a carry out of bit 7.
- R3: Subtract (code 2) and subtract-with-borrow (code 3, which also subtracts incoming C) return A minus the operand. They set N, set Z on a zero byte, set H when the low nibble of the subtrahend plus borrow exceeds the low nibble of A, and set C when the subtrahend plus borrow exceeds A.
- R4: Compare (code 4) produces the same flags as subtract. It returns `acc_i` unchanged on `res_o`, and `wr_en_o` is low.
- R5: AND, OR and XOR return the bitwise result with Z from it and N=0 and C=0. H is 1 for AND and 0 for OR and XOR.
- R6: Increment and decrement return the operand plus or minus one, wrapping at the byte boundary. Z comes from the result. Increment clears N and sets H when the operand's low nibble is 0xF. Decrement sets N and sets H when the operand's low nibble is 0x0. C keeps its incoming value.
- R7: Invert accumulator returns the bitwise inverse of A and sets N and H. Z and C keep their incoming values.
- R8: Set carry forces C to 1, and invert carry flips C. Both clear N and H, keep Z, and return A unchanged with `wr_en_o` low.
- R9: When N is 0, decimal adjust adds 0x06 if H is set or the low nibble of A exceeds 9. It adds 0x60, and sets C, if C is set or A exceeds 0x99. Both tests use the unadjusted A. Adding two packed-BCD bytes and then adjusting yields their decimal sum modulo 100, with C marking a decimal overflow.
- R10: When N is 1, decimal adjust subtracts 0x06 if H is set and 0x60 if C is set, and C keeps its value. For every decimal adjust, Z comes from the result, H is cleared and N is kept.
- R11: Codes 14 and 15 return `acc_i`, copy the upper nibble of `flags_i`, and hold `wr_en_o` low.
- R12: `wr_en_o` is high exactly for codes 0-3 and 5-10 and for code 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; the sole source for increment and decrement |
| flags_i | input | 8 | Incoming flag byte, Z/N/H/C in bits 7..4 |
| res_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte, low nibble zero |
| wr_en_o | output | 1 | Result should be stored |

## Verification
The hardest case to reach is decimal adjust fed a flag byte that no real preceding add or subtract could have left behind. Examples are H set with a low nibble that is already valid, or C set together with a large A. Real instruction streams reach only a small part of that space. The bench drives `flags_i` directly and sweeps every accumulator value against all eight N/H/C combinations. It also chains real BCD additions and subtractions through the block, feeding each flag byte back, and compares the outcome with decimal arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SETC = 4'd11,
    OP_INVC = 4'd12,
    OP_DADJ = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         half_o,
  output logic         carry_o
);
  localparam int H = W / 2;

  logic [W:0] full_w;
  logic [H:0] low_w;

  always_comb begin
    if (sub_i) begin
      full_w = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      low_w  = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, cin_i};
    end else begin
      full_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      low_w  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
    end
  end

  assign res_o   = full_w[W-1:0];
  assign carry_o = full_w[W];
  assign half_o  = low_w[H];

  // R2: adding zero with no carry-in can never carry out
  always_comb begin
    if (!sub_i && b_i == '0 && !cin_i) begin
      p_add_zero_nocarry_r2: assert (!carry_o && !half_o && res_o == a_i);
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::logic_sel_e sel_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic [W-1:0]         res_o
);
  import alu8_pkg::*;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_AND:  res_o[gi] = a_i[gi] & b_i[gi];
        LG_OR:   res_o[gi] = a_i[gi] | b_i[gi];
        LG_XOR:  res_o[gi] = a_i[gi] ^ b_i[gi];
        default: res_o[gi] = ~a_i[gi];
      endcase
    end
  end
endmodule

// File: rtl/alu8_bcd_adj.sv
module alu8_bcd_adj (
  input  logic [7:0] a_i,
  input  logic       n_i,
  input  logic       h_i,
  input  logic       c_i,
  output logic [7:0] res_o,
  output logic       c_o
);
  logic       lo_fix;
  logic       hi_fix;
  logic [7:0] corr;

  always_comb begin
    if (n_i) begin
      lo_fix = h_i;
      hi_fix = c_i;
    end else begin
      lo_fix = h_i | (a_i[3:0] > 4'd9);
      hi_fix = c_i | (a_i > 8'h99);
    end
    corr  = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    res_o = n_i ? (a_i - corr) : (a_i + corr);
    c_o   = hi_fix;
  end

  // R9: a carry entering the adjust is never lost
  always_comb begin
    if (c_i) begin
      p_daa_carry_keep_r9: assert (c_o);
    end
  end

  // R10: after a subtract with no pending corrections A passes through
  always_comb begin
    if (n_i && !h_i && !c_i) begin
      p_daa_sub_pass_r10: assert (res_o == a_i && !c_o);
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core (
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);
  import alu8_pkg::*;

  flag_t      fin;
  flag_t      fout;
  alu_op_e    op;
  logic [7:0] as_a;
  logic [7:0] as_b;
  logic       as_cin;
  logic       as_sub;
  logic [7:0] as_res;
  logic       as_half;
  logic       as_carry;
  logic_sel_e lg_sel;
  logic [7:0] lg_res;
  logic [7:0] bcd_res;
  logic       bcd_c;
  logic       is_incdec;
  logic       is_sub;

  assign fin       = flag_t'(flags_i[7:4]);
  assign op        = alu_op_e'(op_i);
  assign is_incdec = (op == OP_INC) || (op == OP_DEC);
  assign is_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);

  // operand steering into the shared adder
  always_comb begin
    as_a   = is_incdec ? opnd_i : acc_i;
    as_b   = is_incdec ? 8'h00  : opnd_i;
    as_cin = is_incdec ? 1'b1 : (((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0);
    as_sub = is_sub;
  end

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_NOT;
    endcase
  end

  alu8_addsub #(.W(DATA_W)) i_addsub (
    .a_i     (as_a),
    .b_i     (as_b),
    .cin_i   (as_cin),
    .sub_i   (as_sub),
    .res_o   (as_res),
    .half_o  (as_half),
    .carry_o (as_carry)
  );

  alu8_logic #(.W(DATA_W)) i_logic (
    .sel_i (lg_sel),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .res_o (lg_res)
  );

  alu8_bcd_adj i_bcd (
    .a_i   (acc_i),
    .n_i   (fin.n),
    .h_i   (fin.h),
    .c_i   (fin.c),
    .res_o (bcd_res),
    .c_o   (bcd_c)
  );

  always_comb begin
    res_o   = acc_i;
    fout    = fin;
    wr_en_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o   = as_res;
        fout    = '{z: (as_res == 8'h00), n: is_sub, h: as_half, c: as_carry};
        wr_en_o = 1'b1;
      end
      OP_CMP: begin
        fout = '{z: (as_res == 8'h00), n: 1'b1, h: as_half, c: as_carry};
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o   = lg_res;
        fout    = '{z: (lg_res == 8'h00), n: 1'b0, h: (op == OP_AND), c: 1'b0};
        wr_en_o = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o   = as_res;
        fout    = '{z: (as_res == 8'h00), n: is_sub, h: as_half, c: fin.c};
        wr_en_o = 1'b1;
      end
      OP_CPL: begin
        res_o   = lg_res;
        fout.n  = 1'b1;
        fout.h  = 1'b1;
        wr_en_o = 1'b1;
      end
      OP_SETC: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_INVC: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
      OP_DADJ: begin
        res_o   = bcd_res;
        fout    = '{z: (bcd_res == 8'h00), n: fin.n, h: 1'b0, c: bcd_c};
        wr_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign flags_o = {fout, 4'b0000};

  // R4: compare must not disturb the accumulator
  always_comb begin
    if (op_i == 4'd4) begin
      p_cmp_no_store_r4: assert (!wr_en_o && res_o == acc_i && flags_o[6]);
    end
  end

  // R5: bitwise operations never report a carry
  always_comb begin
    if (op_i == 4'd5 || op_i == 4'd6 || op_i == 4'd7) begin
      p_logic_no_carry_r5: assert (!flags_o[4] && !flags_o[6]);
    end
  end

  // R6: increment and decrement keep the incoming carry
  always_comb begin
    if (op_i == 4'd8 || op_i == 4'd9) begin
      p_incdec_keep_c_r6: assert (flags_o[4] == flags_i[4]);
    end
  end

  // R11: undefined codes are inert
  always_comb begin
    if (op_i >= 4'd14) begin
      p_undef_inert_r11: assert (!wr_en_o && res_o == acc_i && flags_o[7:4] == flags_i[7:4]);
    end
  end

  // R1: the low nibble of the flag byte is always clear
  always_comb begin
    p_flag_low_zero_r1: assert (flags_o[3:0] == 4'b0000);
  end
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op;
  logic [7:0] acc;
  logic [7:0] opnd;
  logic [7:0] fl_in;
  logic [7:0] res;
  logic [7:0] fl_out;
  logic       wr;

  int n_vec  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu8_core i_alu8_core (
    .op_i    (op),
    .acc_i   (acc),
    .opnd_i  (opnd),
    .flags_i (fl_in),
    .res_o   (res),
    .flags_o (fl_out),
    .wr_en_o (wr)
  );

  // expected {wr, result, flag byte} worked out from the requirements
  function automatic logic [16:0] model(input int o, input int a, input int b, input logic [7:0] f);
    int   r;
    int   cin;
    int   corr;
    logic z, n, h, c, w;
    z = f[7]; n = f[6]; h = f[5]; c = f[4];
    r = a; w = 1'b0;
    case (o)
      0, 1: begin
        cin = (o == 1) ? int'(c) : 0;
        r = a + b + cin;
        h = ((a % 16) + (b % 16) + cin) > 15;
        c = r > 255; r = r % 256; z = (r == 0); n = 0; w = 1;
      end
      2, 3, 4: begin
        cin = (o == 3) ? int'(c) : 0;
        h = (a % 16) < ((b % 16) + cin);
        c = a < (b + cin);
        r = (a - b - cin + 512) % 256; z = (r == 0); n = 1;
        if (o == 4) r = a; else w = 1;
      end
      5, 6, 7: begin
        r = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
        z = (r == 0); n = 0; h = (o == 5); c = 0; w = 1;
      end
      8: begin r = (b + 1) % 256; h = (b % 16) == 15; n = 0; z = (r == 0); w = 1; end
      9: begin r = (b + 255) % 256; h = (b % 16) == 0; n = 1; z = (r == 0); w = 1; end
      10: begin r = 255 - a; n = 1; h = 1; w = 1; end
      11: begin c = 1; n = 0; h = 0; end
      12: begin c = !c; n = 0; h = 0; end
      13: begin
        corr = 0;
        if (h || (!n && (a % 16) > 9)) corr += 6;
        if (c || (!n && a > 153)) begin corr += 96; c = !n || c; end
        r = n ? (a - corr + 256) % 256 : (a + corr) % 256;
        z = (r == 0); h = 0; w = 1;
      end
      default: ;
    endcase
    return {w, r[7:0], z, n, h, c, 4'b0000};
  endfunction

  task automatic apply(input string req, input int o, input int a, input int b, input logic [7:0] f);
    logic [16:0] exp_v;
    logic [16:0] act_v;
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; fl_in = f;
    #1;
    exp_v = model(o, a, b, f);
    act_v = {wr, res, fl_out};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got wr=%b res=%02h fl=%02h, want wr=%b res=%02h fl=%02h",
               req, o, a, b, f, act_v[16], act_v[15:8], act_v[7:0], exp_v[16], exp_v[15:8], exp_v[7:0]);
    end
  endtask

  task automatic t_idle;
    // R11 R1: inert state with all-zero inputs and an undefined code
    apply("R11", 15, 0, 0, 8'h00);
    apply("R1", 14, 8'h5A, 8'h33, 8'hFF);
  endtask

  task automatic t_add;
    int bl[8] = '{0, 1, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF1, 8'hFF};
    for (int a = 0; a < 256; a++)
      foreach (bl[k]) begin
        apply("R2", 0, a, bl[k], 8'h00);
        apply("R2", 1, a, bl[k], 8'h10);
        apply("R2", 1, a, bl[k], 8'hE0);
      end
  endtask

  task automatic t_sub_cmp;
    int bl[8] = '{0, 1, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hF1, 8'hFF};
    for (int a = 0; a < 256; a++)
      foreach (bl[k]) begin
        apply("R3", 2, a, bl[k], 8'h00);
        apply("R3", 3, a, bl[k], 8'h10);
        apply("R3", 3, a, bl[k], 8'h00);
        apply("R4", 4, a, bl[k], 8'h30);
      end
    apply("R4", 4, 8'h42, 8'h42, 8'h00);
  endtask

  task automatic t_logic;
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 17) begin
        apply("R5", 5, a, b, 8'hF0);
        apply("R5", 6, a, b, 8'h00);
        apply("R5", 7, a, b, 8'h70);
      end
    apply("R5", 5, 8'hAA, 8'h55, 8'h00);
    apply("R5", 7, 8'h3C, 8'h3C, 8'h10);
  endtask

  task automatic t_incdec;
    for (int b = 0; b < 256; b++) begin
      apply("R6", 8, 8'h99, b, 8'h10);
      apply("R6", 8, 8'h00, b, 8'h60);
      apply("R6", 9, 8'h99, b, 8'h10);
      apply("R6", 9, 8'h00, b, 8'h20);
    end
  endtask

  task automatic t_cpl_carry;
    for (int a = 0; a < 256; a += 5)
      for (int f = 0; f < 16; f++) begin
        apply("R7", 10, a, 8'h11, 8'(f << 4));
        apply("R8", 11, a, 8'h22, 8'(f << 4));
        apply("R8", 12, a, 8'h33, 8'(f << 4));
      end
  endtask

  task automatic t_daa_sweep;
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 8; f++) begin
        apply((f >= 4) ? "R10" : "R9", 13, a, 8'h00, 8'((f << 4) | 8'h80));
        apply((f >= 4) ? "R10" : "R9", 13, a, 8'h00, 8'(f << 4));
      end
  endtask

  // R9 R10: real BCD arithmetic chained through the block
  task automatic t_bcd_chain;
    int          x_bcd;
    int          y_bcd;
    logic [7:0]  sum_b;
    logic [7:0]  fl_b;
    int          want;
    for (int x = 0; x < 100; x += 7)
      for (int y = 0; y < 100; y += 3) begin
        x_bcd = (x / 10) * 16 + (x % 10);
        y_bcd = (y / 10) * 16 + (y % 10);
        op = 4'd0; acc = 8'(x_bcd); opnd = 8'(y_bcd); fl_in = 8'h00;
        #1;
        sum_b = res; fl_b = fl_out;
        op = 4'd13; acc = sum_b; fl_in = fl_b;
        #1;
        want = (x + y) % 100;
        n_vec++;
        if (res !== 8'((want / 10) * 16 + (want % 10)) || fl_out[4] !== ((x + y) > 99)) begin
          n_bad++;
          $display("FAIL R9 %0d+%0d: got res=%02h c=%b, want res=%0d c=%b",
                   x, y, res, fl_out[4], want, (x + y) > 99);
        end
        op = 4'd2; acc = 8'(x_bcd); opnd = 8'(y_bcd); fl_in = 8'h00;
        #1;
        sum_b = res; fl_b = fl_out;
        op = 4'd13; acc = sum_b; fl_in = fl_b;
        #1;
        want = (x - y + 100) % 100;
        n_vec++;
        if (res !== 8'((want / 10) * 16 + (want % 10)) || fl_out[4] !== (x < y)) begin
          n_bad++;
          $display("FAIL R10 %0d-%0d: got res=%02h c=%b, want res=%0d c=%b",
                   x, y, res, fl_out[4], want, x < y);
        end
      end
  endtask

  task automatic t_wr_table;
    // R12: write-enable over every code
    for (int o = 0; o < 16; o++) apply("R12", o, 8'h37, 8'h48, 8'hA0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, want fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    op = 4'd15; acc = 8'h00; opnd = 8'h00; fl_in = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_idle();
    t_add();
    t_sub_cmp();
    t_logic();
    t_incdec();
    t_cpl_carry();
    t_daa_sweep();
    t_bcd_chain();
    t_wr_table();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule